// File: doc/BRIEF.md
# Oscillator and Processor Clock Controller

This block holds the software-visible controls for a pair of oscillators, a fast one that feeds a 4x PLL and a slow one. It also holds the choice of which derived clock drives the processor, and it runs the sleep and wakeup sequence. Software writes two byte-wide registers over a plain address/data/write-strobe bus.

The control register has three bits. Bit 0 is an active-low enable for the fast oscillator, and the PLL enable follows it. Bit 1 is an active-high enable for the slow oscillator. Bit 2 picks the processor clock: 0 selects the PLL-derived fast clock and 1 selects the slow clock. The source register has two bits. Bit 2 chooses the source of the slow oscillator, and bit 7 is a lock that freezes bit 2 against writes.

A sleep request stops the processor and turns both oscillators off. A later wakeup event re-enables the oscillator named by the clock select. When that oscillator is the fast one, the processor is held for a counted stabilization interval before it runs. When it is the slow one, the processor restarts at once. The block drives enables and selects only. The analog oscillators, the PLL and the clock multiplexer lie outside it.

Top module: `clk_osc_ctrl`

## Requirements
- R1: After reset both registers read 0. Outputs are then fast_osc_en=1, pll_en=1, slow_osc_en=0, pclk_sel_slow=0, slow_src_rc=0 and cpu_run=1.
- R2: Control bit 0 is an active-low enable for the fast oscillator. Writing 1 drives fast_osc_en and pll_en low after the write edge, and writing 0 drives both high.
- R3: Control bit 1 is an active-high enable for the slow oscillator and drives slow_osc_en.
- R4: Control bit 2 drives pclk_sel_slow (1 = slow clock) at any time. Selecting an oscillator that is disabled is accepted.
- R5: In the source register, bit 7 (lock) is always writable. Bit 2 (slow_src_rc, 1 = internal RC, 0 = crystal) takes the written value only when the lock held before that write is 0.
- R6: Reads are combinational from addr. Address CTRL_ADDR returns the control bits in [2:0] and address SRC_ADDR returns bits 7 and 2. All other bits, and all other addresses, read 0.
- R7: A sleep_req while the processor is running drops cpu_run after the next edge. It also sets control bit 0 to 1 and clears bit 1, so both oscillator enables and pll_en go low.
- R8: A wake_evt while asleep with control bit 2 at 0 clears bit 0 after the next edge. cpu_run then stays low for exactly 2^STALL_W cycles counted from that edge.
- R9: A wake_evt while asleep with control bit 2 at 1 sets bit 1, and cpu_run is high after the next edge with no stall.
- R10: A wake_evt during a stall does not restart the count. A wake_evt while the processor is running has no effect.
- R11: A sleep_req during sleep or during a stall has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (fast-oscillator domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wakeup event |
| fast_osc_en | output | 1 | Fast oscillator enable |
| pll_en | output | 1 | PLL enable |
| slow_osc_en | output | 1 | Slow oscillator enable |
| pclk_sel_slow | output | 1 | Processor clock select, 1 = slow |
| slow_src_rc | output | 1 | Slow oscillator source, 1 = internal RC |
| cpu_run | output | 1 | Processor may run |

## Verification
The bench builds the block with STALL_W=4, which shortens the stabilization interval to 16 cycles. At that length the exact stall boundary can be checked cycle by cycle, and a stray wakeup and a sleep request can both be injected in the middle of a stall. The register map keeps its default addresses, and an unmapped address is read as well. The default width of 16 is covered only by the elaboration checks.

// File: rtl/clkc_pkg.sv
package clkc_pkg;
   typedef enum logic [1:0] {PS_RUN = 2'd0, PS_SLEEP = 2'd1, PS_STALL = 2'd2} pwr_state_t;
   // control register bit positions
   localparam int CB_FAST_OFF = 0;
   localparam int CB_SLOW_ON  = 1;
   localparam int CB_SEL_SLOW = 2;
   // source register bit positions
   localparam int SB_SRC_RC   = 2;
   localparam int SB_LOCK     = 7;
endpackage

// File: rtl/clkc_stall_timer.sv
module clkc_stall_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         active,
   output logic [W-1:0] cnt,
   output logic         last
);
   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= '0;
      else if (active) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CNT_MAX);
endmodule

// File: rtl/clkc_pwr_fsm.sv
module clkc_pwr_fsm
   import clkc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_evt,
   input  logic sel_slow,
   input  logic stall_last,
   output logic frc_sleep,
   output logic frc_fast_on,
   output logic frc_slow_on,
   output logic in_sleep,
   output logic in_stall,
   output logic cpu_run
);
   pwr_state_t state, state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         PS_RUN:   if (sleep_req) state_nx = PS_SLEEP;
         PS_SLEEP: if (wake_evt)  state_nx = sel_slow ? PS_RUN : PS_STALL;
         PS_STALL: if (stall_last) state_nx = PS_RUN;
         default:  state_nx = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_RUN;
      else        state <= state_nx;
   end

   assign in_sleep    = (state == PS_SLEEP);
   assign in_stall    = (state == PS_STALL);
   assign cpu_run     = (state == PS_RUN);
   assign frc_sleep   = cpu_run && sleep_req;
   assign frc_fast_on = in_sleep && wake_evt && !sel_slow;
   assign frc_slow_on = in_sleep && wake_evt && sel_slow;
endmodule

// File: rtl/clkc_regs.sv
module clkc_regs
   import clkc_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int SRC_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              frc_sleep,
   input  logic              frc_fast_on,
   input  logic              frc_slow_on,
   output logic              fast_off,
   output logic              slow_on,
   output logic              sel_slow,
   output logic              src_rc,
   output logic              src_lock,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(SRC_ADDR);

   logic wr_ctrl, wr_src;
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_src  = wr_en && (addr == A_SRC);

   // control register: bus write first, hardware sequencing overrides
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_off <= 1'b0;
         slow_on  <= 1'b0;
         sel_slow <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            fast_off <= wdata[CB_FAST_OFF];
            slow_on  <= wdata[CB_SLOW_ON];
            sel_slow <= wdata[CB_SEL_SLOW];
         end
         if (frc_sleep) begin
            fast_off <= 1'b1;
            slow_on  <= 1'b0;
         end
         if (frc_fast_on) fast_off <= 1'b0;
         if (frc_slow_on) slow_on  <= 1'b1;
      end
   end

   // source register with write lock on the source bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_rc   <= 1'b0;
         src_lock <= 1'b0;
      end else if (wr_src) begin
         src_lock <= wdata[SB_LOCK];
         if (!src_lock) src_rc <= wdata[SB_SRC_RC];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CTRL) begin
         rdata[CB_FAST_OFF] = fast_off;
         rdata[CB_SLOW_ON]  = slow_on;
         rdata[CB_SEL_SLOW] = sel_slow;
      end else if (addr == A_SRC) begin
         rdata[SB_SRC_RC] = src_rc;
         rdata[SB_LOCK]   = src_lock;
      end
   end
endmodule

// File: rtl/clk_osc_ctrl.sv
module clk_osc_ctrl #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int SRC_ADDR  = 1,
   parameter int STALL_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              sleep_req,
   input  logic              wake_evt,
   output logic              fast_osc_en,
   output logic              pll_en,
   output logic              slow_osc_en,
   output logic              pclk_sel_slow,
   output logic              slow_src_rc,
   output logic              cpu_run
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < 8) begin : g_bad_data_w
      $error("clk_osc_ctrl: DATA_W must be at least 8");
   end
   if (STALL_W < 2) begin : g_bad_stall_w
      $error("clk_osc_ctrl: STALL_W must be at least 2");
   end
   if (CTRL_ADDR == SRC_ADDR) begin : g_bad_map
      $error("clk_osc_ctrl: register addresses must differ");
   end
   if (CTRL_ADDR >= ADDR_SPAN || SRC_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("clk_osc_ctrl: register address outside ADDR_W");
   end

   logic fast_off, slow_on, sel_slow, src_rc, src_lock;
   logic frc_sleep, frc_fast_on, frc_slow_on;
   logic in_sleep, in_stall, stall_last;
   logic [STALL_W-1:0] stall_cnt;

   clkc_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .SRC_ADDR(SRC_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .frc_sleep(frc_sleep), .frc_fast_on(frc_fast_on), .frc_slow_on(frc_slow_on),
      .fast_off(fast_off), .slow_on(slow_on), .sel_slow(sel_slow),
      .src_rc(src_rc), .src_lock(src_lock), .rdata(rdata)
   );

   clkc_pwr_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
      .sel_slow(sel_slow), .stall_last(stall_last),
      .frc_sleep(frc_sleep), .frc_fast_on(frc_fast_on), .frc_slow_on(frc_slow_on),
      .in_sleep(in_sleep), .in_stall(in_stall), .cpu_run(cpu_run)
   );

   clkc_stall_timer #(.W(STALL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(frc_fast_on), .active(in_stall),
      .cnt(stall_cnt), .last(stall_last)
   );

   assign fast_osc_en   = ~fast_off;
   assign pll_en        = ~fast_off;
   assign slow_osc_en   = slow_on;
   assign pclk_sel_slow = sel_slow;
   assign slow_src_rc   = src_rc;
endmodule

// File: rtl/clkc_checker.sv
module clkc_checker #(
   parameter int ADDR_W   = 4,
   parameter int SRC_ADDR = 1,
   parameter int STALL_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              sleep_req,
   input logic              wake_evt,
   input logic              fast_osc_en,
   input logic              slow_osc_en,
   input logic              pclk_sel_slow,
   input logic              slow_src_rc,
   input logic              cpu_run,
   input logic              in_sleep,
   input logic              in_stall,
   input logic              src_lock,
   input logic [STALL_W-1:0] stall_cnt
);
   localparam logic [STALL_W-1:0] CNT_MAX = '1;

   p_sleep_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_run && sleep_req |=> !cpu_run && !fast_osc_en && !slow_osc_en);

   p_wake_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_sleep && wake_evt && !pclk_sel_slow |=> !cpu_run && fast_osc_en);

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_stall |-> !cpu_run);

   p_wake_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_sleep && wake_evt && pclk_sel_slow |=> cpu_run && slow_osc_en);

   p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_stall && (stall_cnt != CNT_MAX) |=>
         in_stall && (stall_cnt == STALL_W'($past(stall_cnt) + 1'b1)));

   p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (addr == ADDR_W'(SRC_ADDR)) && src_lock |=> $stable(slow_src_rc));

   p_sleep_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_sleep && !wake_evt |=> in_sleep && !cpu_run);
endmodule

bind clk_osc_ctrl clkc_checker #(
   .ADDR_W(ADDR_W), .SRC_ADDR(SRC_ADDR), .STALL_W(STALL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .sleep_req(sleep_req), .wake_evt(wake_evt),
   .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en),
   .pclk_sel_slow(pclk_sel_slow), .slow_src_rc(slow_src_rc), .cpu_run(cpu_run),
   .in_sleep(in_sleep), .in_stall(in_stall), .src_lock(src_lock),
   .stall_cnt(stall_cnt)
);

// File: tb/clk_osc_ctrl_test.sv
module clk_osc_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W  = 4;
   localparam int DATA_W  = 8;
   localparam int STALL_W = 4;
   localparam int STALL_LEN = 1 << STALL_W;

   localparam int K_RUN = 0, K_FAST = 1, K_PLL = 2, K_SLOW = 3, K_SEL = 4, K_SRC = 5, K_RD = 6;

   typedef struct {
      int          kind;
      logic [7:0]  exp;
      string       req;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic sleep_req = 1'b0;
   logic wake_evt = 1'b0;
   logic [DATA_W-1:0] rdata;
   logic fast_osc_en, pll_en, slow_osc_en, pclk_sel_slow, slow_src_rc, cpu_run;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_osc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STALL_W(STALL_W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .sleep_req(sleep_req), .wake_evt(wake_evt),
      .fast_osc_en(fast_osc_en), .pll_en(pll_en), .slow_osc_en(slow_osc_en),
      .pclk_sel_slow(pclk_sel_slow), .slow_src_rc(slow_src_rc), .cpu_run(cpu_run)
   );

   function automatic logic [7:0] observe(int kind);
      case (kind)
         K_RUN:   return {7'd0, cpu_run};
         K_FAST:  return {7'd0, fast_osc_en};
         K_PLL:   return {7'd0, pll_en};
         K_SLOW:  return {7'd0, slow_osc_en};
         K_SEL:   return {7'd0, pclk_sel_slow};
         K_SRC:   return {7'd0, slow_src_rc};
         default: return rdata;
      endcase
   endfunction

   task automatic expect_item(int kind, logic [7:0] exp, string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic expect_rd(logic [ADDR_W-1:0] a, logic [7:0] d, string req);
      addr = a;
      expect_item(K_RD, d, req);
      tick();
   endtask

   // monitor: compares expectations a moment after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] obs;
            it = q.pop_front();
            obs = observe(it.kind);
            checks++;
            if (obs !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%0h expected=%0h at %0t",
                        it.req, it.kind, obs, it.exp, $time);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_item(K_FAST, 8'd1, "R1"); expect_item(K_PLL, 8'd1, "R1");
      expect_item(K_SLOW, 8'd0, "R1"); expect_item(K_SEL, 8'd0, "R1");
      expect_item(K_SRC, 8'd0, "R1");  expect_item(K_RUN, 8'd1, "R1");
      expect_rd(4'd0, 8'h00, "R1");
      expect_rd(4'd1, 8'h00, "R1");

      // R2 fast oscillator active-low enable and PLL follow
      wr(4'd0, 8'h01);
      expect_item(K_FAST, 8'd0, "R2"); expect_item(K_PLL, 8'd0, "R2");
      wr(4'd0, 8'h00);
      expect_item(K_FAST, 8'd1, "R2"); expect_item(K_PLL, 8'd1, "R2");

      // R3 slow oscillator enable
      wr(4'd0, 8'h02);
      expect_item(K_SLOW, 8'd1, "R3");
      expect_rd(4'd0, 8'h02, "R3");

      // R4 selecting a disabled slow oscillator is accepted
      wr(4'd0, 8'h04);
      expect_item(K_SEL, 8'd1, "R4"); expect_item(K_SLOW, 8'd0, "R4");
      wr(4'd0, 8'h00);
      expect_item(K_SEL, 8'd0, "R4");

      // R6 unused bits and unmapped address
      wr(4'd0, 8'hFF);
      expect_rd(4'd0, 8'h07, "R6");
      expect_rd(4'd3, 8'h00, "R6");

      // R5 lock on slow source bit
      wr(4'd1, 8'h04);
      expect_item(K_SRC, 8'd1, "R5");
      expect_rd(4'd1, 8'h04, "R5");
      wr(4'd1, 8'h80);
      expect_item(K_SRC, 8'd0, "R5");
      wr(4'd1, 8'h84);
      expect_item(K_SRC, 8'd0, "R5");
      expect_rd(4'd1, 8'h80, "R5");
      wr(4'd1, 8'h04);
      expect_rd(4'd1, 8'h00, "R5");
      wr(4'd1, 8'h04);
      expect_item(K_SRC, 8'd1, "R5");

      // R7 sleep from running, fast select
      wr(4'd0, 8'h02);
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
      expect_item(K_RUN, 8'd0, "R7"); expect_item(K_FAST, 8'd0, "R7");
      expect_item(K_PLL, 8'd0, "R7"); expect_item(K_SLOW, 8'd0, "R7");
      expect_rd(4'd0, 8'h01, "R7");

      // R11 sleep request while asleep is ignored
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
      expect_item(K_RUN, 8'd0, "R11"); expect_item(K_FAST, 8'd0, "R11");

      // R8 wake into fast clock with stall; R10 and R11 injected mid-stall
      wake_evt = 1'b1; tick(); wake_evt = 1'b0;
      expect_item(K_RUN, 8'd0, "R8"); expect_item(K_FAST, 8'd1, "R8");
      for (int i = 1; i <= STALL_LEN; i++) begin
         if (i == 5) wake_evt = 1'b1;
         if (i == 9) sleep_req = 1'b1;
         tick();
         wake_evt = 1'b0;
         sleep_req = 1'b0;
         if (i < STALL_LEN) begin
            expect_item(K_RUN, 8'd0, (i > 5) ? "R10" : "R8");
            if (i == 9) expect_item(K_FAST, 8'd1, "R11");
         end else begin
            expect_item(K_RUN, 8'd1, "R8");
         end
      end
      tick();

      // R9 wake into slow clock, no stall
      wr(4'd0, 8'h04);
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
      expect_item(K_SLOW, 8'd0, "R9");
      wake_evt = 1'b1; tick(); wake_evt = 1'b0;
      expect_item(K_RUN, 8'd1, "R9"); expect_item(K_SLOW, 8'd1, "R9");
      expect_item(K_FAST, 8'd0, "R9");
      expect_rd(4'd0, 8'h07, "R9");

      // R10 wake while running has no effect
      wr(4'd0, 8'h04);
      wake_evt = 1'b1; tick(); wake_evt = 1'b0;
      expect_item(K_SLOW, 8'd0, "R10"); expect_item(K_RUN, 8'd1, "R10");
      expect_rd(4'd0, 8'h04, "R10");

      repeat (3) tick();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule